// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block turns three reset requests into one ordered start-up sequence for a processor: a level on the bidirectional reset pad (active low), a digital low-supply flag, and a one-cycle watchdog underflow pulse. Low pulses on the pad that are shorter than a minimum number of clocks are dropped. Once a request is accepted, the sequencer enters a hold step. When the cause of the request goes away, it counts a fixed oscillator-settling delay and then spends two cycles fetching the reset vector. After that the processor runs.

The two internal sources also pull the shared pad low so that other devices on the board reset too. The low-supply source holds the pad through both the hold step and the settling delay. The watchdog holds it only for a short fixed width. An external request never drives the pad. A two-bit cause field shows which source started the most recent sequence. Software reads that field once the sequence is back in the run step. Any new request, in any step, restarts the sequence.

Top module: `reset_sequencer`

## Requirements
- R1: While `rst_n` is low at a clock edge, the sequencer goes to the settling step (phase 2) with cause 0 (power-on), `sys_rst_o` high and `pin_drive_o` low.
- R2: The settling step lasts exactly STAB_CYCLES (default 4096) cycles after the cycle in which it is entered, and is followed by the fetch step.
- R3: The fetch step (phase 3) lasts exactly two cycles, with `vec_fetch_o` high. `vec_addr_o` is FFFEh in the first cycle and FFFFh in the second. The run step (phase 0) follows.
- R4: The sequencer ignores a low level on `pin_rst_n_i` that lasts fewer than PULSE_MIN (default 4) consecutive sampled clocks. After PULSE_MIN consecutive low samples, the hold step (phase 1) with cause 1 is visible in the cycle after the last of those samples.
- R5: An external hold lasts while the pad stays low. Settling begins in the cycle after the first high sample. `pin_drive_o` stays low throughout an external sequence.
- R6: A low-supply request (cause 2) holds the hold step for as long as `lvd_low_i` is high. Settling starts in the cycle after the first low sample. `pin_drive_o` is high through both the hold step and the settling step.
- R7: A watchdog pulse (cause 3) gives a hold step of exactly WDG_WIDTH (default 8) cycles with `pin_drive_o` high. Settling follows with the pad released.
- R8: A new request in any step restarts the sequence at the hold step. When requests coincide, low-supply wins over watchdog, and watchdog wins over external.
- R9: Cause encoding is 0 power-on, 1 external, 2 low-supply, 3 watchdog. The value is held unchanged until the next accepted request, including through the run step.
- R10: `sys_rst_o` is high in every phase except run (phase 0), and `pin_drive_o` is low in run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset of the sequencer |
| pin_rst_n_i | input | 1 | Sampled level of the reset pad, low = reset requested |
| lvd_low_i | input | 1 | Low-supply flag, high while supply is below threshold |
| wdg_uf_i | input | 1 | Watchdog underflow pulse |
| sys_rst_o | output | 1 | Internal reset, high = in reset |
| pin_drive_o | output | 1 | Open-drain enable: pull the reset pad low |
| vec_fetch_o | output | 1 | High during the two vector-fetch cycles |
| vec_addr_o | output | 16 | Vector byte address during fetch, zero otherwise |
| phase_o | output | 2 | Step: 0 run, 1 hold, 2 settle, 3 fetch |
| cause_o | output | 2 | Source of the last reset (see R9) |

## Verification
Every output comes from a register, so a request sampled at edge n shows as the hold step in the following cycle. The settling count, the fetch cycles and the run step then fall at fixed offsets: entry+4096, entry+4097 and entry+4098. Pad filtering delays acceptance by PULSE_MIN sampled edges, and the watchdog hold ends WDG_WIDTH cycles after entry. The driver computes the cycle of each expected item from these offsets and queues it. The monitor compares all outputs at the falling edge of exactly that cycle, so no sample lands on a register update.

// File: rtl/rstseq_pkg.sv
// Shared types for the reset sequencer: step and cause encodings and the
// fixed reset-vector address. Assumes a 16-bit vector address space.
package rstseq_pkg;
    typedef enum logic [1:0] {
        PH_RUN    = 2'd0,
        PH_ASSERT = 2'd1,
        PH_DELAY  = 2'd2,
        PH_FETCH  = 2'd3
    } phase_t;

    typedef enum logic [1:0] {
        SRC_POR = 2'd0,
        SRC_EXT = 2'd1,
        SRC_LVD = 2'd2,
        SRC_WDG = 2'd3
    } src_t;

    localparam logic [15:0] RESET_VECTOR = 16'hFFFE;
    localparam int          FETCH_LEN    = 2;
endpackage

// File: rtl/rstseq_pin_filter.sv
// Glitch filter for the reset pad. Emits a one-cycle request once the pad
// has been sampled low for MIN_LOW consecutive clocks. Counting is suspended
// while the block itself pulls the pad low (mask), so self-driven lows are
// never taken for an external request. Assumes MIN_LOW >= 1.
module rstseq_pin_filter #(
    parameter int MIN_LOW = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    input  logic mask,
    output logic req
);
    localparam int W = $clog2(MIN_LOW + 1);

    logic [W-1:0] run_q;

    // Count consecutive low samples, saturating at MIN_LOW.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (mask || pin_n) begin
            run_q <= '0;
        end else if (run_q != W'(MIN_LOW)) begin
            run_q <= run_q + 1'b1;
        end
    end

    // Single request on the sample that completes the minimum width.
    assign req = !mask && !pin_n && (run_q == W'(MIN_LOW - 1));
endmodule

// File: rtl/rstseq_fsm.sv
// Step controller: hold, settle, fetch, run. Records the cause of the last
// accepted request. Requests are prioritised LVD > WDG > EXT and restart the
// sequence from any step. Assumes WDG_W >= 1 and STAB >= 1.
module rstseq_fsm
    import rstseq_pkg::*;
#(
    parameter int STAB  = 4096,
    parameter int WDG_W = 8
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   lvd,
    input  logic   wdg,
    input  logic   ext_req,
    input  logic   pin_n,
    output phase_t phase,
    output src_t   cause,
    output logic   cnt_lsb
);
    localparam int MAXC = (STAB > WDG_W) ? STAB : WDG_W;
    localparam int CW   = $clog2(MAXC + 1);

    phase_t        phase_q, phase_d;
    src_t          cause_q, cause_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // Next-step logic: restart on any request, otherwise advance the step.
    always_comb begin
        phase_d = phase_q;
        cause_d = cause_q;
        cnt_d   = cnt_q;
        if (lvd) begin
            phase_d = PH_ASSERT; cause_d = SRC_LVD; cnt_d = '0;
        end else if (wdg) begin
            phase_d = PH_ASSERT; cause_d = SRC_WDG; cnt_d = '0;
        end else if (ext_req) begin
            phase_d = PH_ASSERT; cause_d = SRC_EXT; cnt_d = '0;
        end else begin
            unique case (phase_q)
                PH_ASSERT: begin
                    if (cause_q == SRC_WDG) begin
                        if (cnt_q == CW'(WDG_W - 1)) begin
                            phase_d = PH_DELAY; cnt_d = '0;
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                        end
                    end else if (cause_q == SRC_EXT) begin
                        if (pin_n) begin
                            phase_d = PH_DELAY; cnt_d = '0;
                        end
                    end else begin
                        phase_d = PH_DELAY; cnt_d = '0;
                    end
                end
                PH_DELAY: begin
                    if (cnt_q == CW'(STAB - 1)) begin
                        phase_d = PH_FETCH; cnt_d = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                PH_FETCH: begin
                    if (cnt_q == CW'(FETCH_LEN - 1)) begin
                        phase_d = PH_RUN; cnt_d = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                default: begin
                    phase_d = PH_RUN;
                end
            endcase
        end
    end

    // State registers; power-on reset starts in the settling step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_DELAY;
            cause_q <= SRC_POR;
            cnt_q   <= '0;
        end else begin
            phase_q <= phase_d;
            cause_q <= cause_d;
            cnt_q   <= cnt_d;
        end
    end

    assign phase   = phase_q;
    assign cause   = cause_q;
    assign cnt_lsb = cnt_q[0];
endmodule

// File: rtl/rstseq_outdec.sv
// Output decode from the registered step and cause: internal reset, pad
// pull-down enable, fetch strobe and vector address. Purely combinational.
module rstseq_outdec
    import rstseq_pkg::*;
(
    input  phase_t      phase,
    input  src_t        cause,
    input  logic        cnt_lsb,
    output logic        sys_rst,
    output logic        pin_drive,
    output logic        vec_fetch,
    output logic [15:0] vec_addr
);
    // Decode outputs; LVD drives the pad through hold and settle, WDG in hold.
    always_comb begin
        sys_rst   = (phase != PH_RUN);
        vec_fetch = (phase == PH_FETCH);
        pin_drive = ((phase == PH_ASSERT) && (cause == SRC_LVD || cause == SRC_WDG)) ||
                    ((phase == PH_DELAY) && (cause == SRC_LVD));
        vec_addr  = vec_fetch ? (RESET_VECTOR | {15'd0, cnt_lsb}) : 16'd0;
    end
endmodule

// File: rtl/reset_sequencer.sv
// Top of the reset sequencer. Combines pad, low-supply and watchdog requests
// into hold / settle / fetch / run steps. Assumes all inputs are already
// synchronous to clk; the pad level read back includes the block's own drive.
module reset_sequencer #(
    parameter int STAB_CYCLES = 4096,
    parameter int PULSE_MIN   = 4,
    parameter int WDG_WIDTH   = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pin_rst_n_i,
    input  logic        lvd_low_i,
    input  logic        wdg_uf_i,
    output logic        sys_rst_o,
    output logic        pin_drive_o,
    output logic        vec_fetch_o,
    output logic [15:0] vec_addr_o,
    output logic [1:0]  phase_o,
    output logic [1:0]  cause_o
);
    import rstseq_pkg::*;

    logic   ext_req;
    logic   cnt_lsb;
    phase_t phase;
    src_t   cause;

    rstseq_pin_filter #(.MIN_LOW(PULSE_MIN)) u_filter (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_n (pin_rst_n_i),
        .mask  (pin_drive_o),
        .req   (ext_req)
    );

    rstseq_fsm #(.STAB(STAB_CYCLES), .WDG_W(WDG_WIDTH)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .lvd     (lvd_low_i),
        .wdg     (wdg_uf_i),
        .ext_req (ext_req),
        .pin_n   (pin_rst_n_i),
        .phase   (phase),
        .cause   (cause),
        .cnt_lsb (cnt_lsb)
    );

    rstseq_outdec u_dec (
        .phase     (phase),
        .cause     (cause),
        .cnt_lsb   (cnt_lsb),
        .sys_rst   (sys_rst_o),
        .pin_drive (pin_drive_o),
        .vec_fetch (vec_fetch_o),
        .vec_addr  (vec_addr_o)
    );

    assign phase_o = phase;
    assign cause_o = cause;
endmodule

// File: rtl/reset_sequencer_chk.sv
// Property checker for reset_sequencer, attached by bind. Observes ports only.
module reset_sequencer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        pin_rst_n_i,
    input logic        lvd_low_i,
    input logic        wdg_uf_i,
    input logic        sys_rst_o,
    input logic        pin_drive_o,
    input logic        vec_fetch_o,
    input logic [15:0] vec_addr_o,
    input logic [1:0]  phase_o,
    input logic [1:0]  cause_o
);
    AST_FETCH_FROM_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == 2'd3 && $past(phase_o) != 2'd3) |-> $past(phase_o) == 2'd2); // R2

    AST_FETCH_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(vec_fetch_o) && !lvd_low_i && !wdg_uf_i && pin_rst_n_i) |=> vec_fetch_o); // R3

    AST_FETCH_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_fetch_o && $past(vec_fetch_o)) |=> !vec_fetch_o); // R3

    AST_VEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        vec_fetch_o |-> vec_addr_o[15:1] == 15'h7FFF); // R3

    AST_EXT_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        cause_o == 2'd1 |-> !pin_drive_o); // R5

    AST_LVD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        lvd_low_i |=> (phase_o == 2'd1 && cause_o == 2'd2 && pin_drive_o)); // R6

    AST_WDG_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (wdg_uf_i && !lvd_low_i) |=> (phase_o == 2'd1 && cause_o == 2'd3)); // R8

    AST_RUN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        phase_o == 2'd0 |-> (!sys_rst_o && !pin_drive_o)); // R10
endmodule

bind reset_sequencer reset_sequencer_chk u_chk (.*);

// File: tb/reset_sequencer_test.sv
module reset_sequencer_test;
    localparam int STAB = 4096;
    localparam int WDGW = 8;

    typedef struct {
        int          at;
        logic [1:0]  ph;
        logic [1:0]  cs;
        logic        drv;
        logic [15:0] addr;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_force = 1'b0;
    logic        lvd = 1'b0;
    logic        wdg = 1'b0;
    logic        pin_n;
    logic        sys_rst, drive, fetch;
    logic [15:0] addr;
    logic [1:0]  phase, cause;

    int    cyc = 0;
    int    checks = 0;
    int    failures = 0;
    item_t q[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Open-drain pad: low if the board or the block pulls it.
    assign pin_n = ~(ext_force | drive);

    reset_sequencer uut (
        .clk(clk), .rst_n(rst_n), .pin_rst_n_i(pin_n), .lvd_low_i(lvd),
        .wdg_uf_i(wdg), .sys_rst_o(sys_rst), .pin_drive_o(drive),
        .vec_fetch_o(fetch), .vec_addr_o(addr), .phase_o(phase), .cause_o(cause)
    );

    task automatic chk(string tag, int got, int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s at cycle %0d: got %0d expected %0d", tag, cyc, got, exp);
        end
    endtask

    // Monitor: compare queued expectations in their due cycle.
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].at <= cyc) begin
            item_t it;
            it = q.pop_front();
            if (it.at < cyc) chk({it.tag, " missed"}, cyc, it.at);
            chk({it.tag, " phase"}, phase, it.ph);
            chk({"R9 cause/", it.tag}, cause, it.cs);
            chk({"R10 sys_rst/", it.tag}, sys_rst, (it.ph != 2'd0));
            chk({it.tag, " pin_drive"}, drive, it.drv);
            chk({"R3 vec_fetch/", it.tag}, fetch, (it.ph == 2'd3));
            if (it.ph == 2'd3) chk({"R3 vec_addr/", it.tag}, addr, it.addr);
        end
    end

    task automatic expect_at(int at, logic [1:0] ph, logic [1:0] cs, logic drv,
                             logic [15:0] a, string tag);
        item_t it;
        it.at = at; it.ph = ph; it.cs = cs; it.drv = drv; it.addr = a; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic wait_until(int n);
        while (cyc < n) @(negedge clk);
    endtask

    // Settle / fetch / run expectations from the cycle settling is entered.
    task automatic expect_tail(int d0, logic [1:0] cs, logic drv, string tag);
        expect_at(d0 + 1,        2'd2, cs, drv,  16'h0,    {"R2 ", tag});
        expect_at(d0 + STAB - 1, 2'd2, cs, drv,  16'h0,    {"R2 ", tag});
        expect_at(d0 + STAB,     2'd3, cs, 1'b0, 16'hFFFE, {"R3 ", tag});
        expect_at(d0 + STAB + 1, 2'd3, cs, 1'b0, 16'hFFFF, {"R3 ", tag});
        expect_at(d0 + STAB + 2, 2'd0, cs, 1'b0, 16'h0,    {"R3 ", tag});
        wait_until(d0 + STAB + 3);
    endtask

    initial begin : watchdog
        wait (cyc > 60000);
        failures++;
        $display("FAIL watchdog: got cycle %0d expected completion", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : driver
        int c;
        repeat (3) @(negedge clk);
        // R1: power-on reset state
        c = cyc;
        expect_at(c + 1, 2'd2, 2'd0, 1'b0, 16'h0, "R1 por");
        wait_until(c + 1);
        rst_n = 1'b1;
        expect_tail(c + 1, 2'd0, 1'b0, "por");

        // R4: short pad pulse ignored
        c = cyc;
        expect_at(c + 2, 2'd0, 2'd0, 1'b0, 16'h0, "R4 short");
        expect_at(c + 4, 2'd0, 2'd0, 1'b0, 16'h0, "R4 short");
        expect_at(c + 6, 2'd0, 2'd0, 1'b0, 16'h0, "R4 short");
        ext_force = 1'b1;
        wait_until(c + 3);
        ext_force = 1'b0;
        wait_until(c + 7);

        // R4/R5: pad held six samples
        c = cyc;
        expect_at(c + 3, 2'd0, 2'd0, 1'b0, 16'h0, "R4 ext");
        expect_at(c + 4, 2'd1, 2'd1, 1'b0, 16'h0, "R4 ext");
        expect_at(c + 6, 2'd1, 2'd1, 1'b0, 16'h0, "R5 ext");
        expect_at(c + 7, 2'd2, 2'd1, 1'b0, 16'h0, "R5 ext");
        ext_force = 1'b1;
        wait_until(c + 6);
        ext_force = 1'b0;
        expect_tail(c + 7, 2'd1, 1'b0, "ext");

        // R6: low-supply held five samples
        c = cyc;
        expect_at(c + 1, 2'd1, 2'd2, 1'b1, 16'h0, "R6 lvd");
        expect_at(c + 5, 2'd1, 2'd2, 1'b1, 16'h0, "R6 lvd");
        expect_at(c + 6, 2'd2, 2'd2, 1'b1, 16'h0, "R6 lvd");
        lvd = 1'b1;
        wait_until(c + 5);
        lvd = 1'b0;
        expect_tail(c + 6, 2'd2, 1'b1, "lvd");

        // R7: watchdog pulse
        c = cyc;
        expect_at(c + 1, 2'd1, 2'd3, 1'b1, 16'h0, "R7 wdg");
        expect_at(c + WDGW, 2'd1, 2'd3, 1'b1, 16'h0, "R7 wdg");
        expect_at(c + WDGW + 1, 2'd2, 2'd3, 1'b0, 16'h0, "R7 wdg");
        wdg = 1'b1;
        wait_until(c + 1);
        wdg = 1'b0;
        expect_tail(c + WDGW + 1, 2'd3, 1'b0, "wdg");

        // R8: watchdog, then low-supply restart during settling
        c = cyc;
        expect_at(c + 1, 2'd1, 2'd3, 1'b1, 16'h0, "R8 restart");
        expect_at(c + 50, 2'd2, 2'd3, 1'b0, 16'h0, "R8 restart");
        expect_at(c + 101, 2'd1, 2'd2, 1'b1, 16'h0, "R8 restart");
        expect_at(c + 102, 2'd2, 2'd2, 1'b1, 16'h0, "R8 restart");
        wdg = 1'b1;
        wait_until(c + 1);
        wdg = 1'b0;
        wait_until(c + 100);
        lvd = 1'b1;
        wait_until(c + 101);
        lvd = 1'b0;
        expect_tail(c + 102, 2'd2, 1'b1, "R8 restart");

        // R8: coincident requests, low-supply has priority
        c = cyc;
        expect_at(c + 1, 2'd1, 2'd2, 1'b1, 16'h0, "R8 prio");
        expect_at(c + 2, 2'd2, 2'd2, 1'b1, 16'h0, "R8 prio");
        lvd = 1'b1; wdg = 1'b1; ext_force = 1'b1;
        wait_until(c + 1);
        lvd = 1'b0; wdg = 1'b0; ext_force = 1'b0;
        expect_tail(c + 2, 2'd2, 1'b1, "R8 prio");

        repeat (2) @(negedge clk);
        if (q.size() != 0) chk("queue drained", q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule